// File: doc/BRIEF.md
# Reset-Strapped Serial Pin Multiplexer

This block shares two package pins between two pairs of peripheral functions. A strap input is watched while the active-low reset is held. When reset is released, the last settled strap level fixes the mode, and the mode then stays fixed until reset is asserted again. With the strap low, the first pin serves general-purpose I/O bit 5 and the second pin feeds the UART receiver. With the strap high, the first pin carries the serial port's transmit frame sync and the second pin carries its receive frame sync.

The block drives the pad controls (output enable and output data) from whichever peripheral owns each pin. It returns the pad input level to that peripheral. Peripherals that are not connected see a fixed idle level. The strap passes through a synchronizer before it is captured. A read-only status output shows the committed mode.

Top module: `pin_strap_mux`

## Requirements
- R1: When the committed mode is 0 (strap low), pin 0 takes its output enable and data from the GPIO bit and returns its input to `gpioIn`, and pin 1's input is delivered on `uartRx`.
- R2: When the committed mode is 1 (strap high), pin 0 takes its output enable and data from the transmit frame sync and returns its input to `fsxIn`, and pin 1 takes its output enable and data from the receive frame sync and returns its input to `fsrIn`.
- R3: After reset is released, `modeSel` and the routing do not change, whatever the strap does, until reset is asserted again.
- R4: The committed mode is the strap level present at the rising clock edge `SYNC_STAGES` edges before the last edge with reset low. It becomes the new level only when the strap has been stable for at least `SYNC_STAGES`+1 edges before release.
- R5: While reset is low, and until the first rising clock edge after release, both pad output enables are 0 whatever the peripheral enables are.
- R6: Unconnected peripheral inputs sit at fixed idle levels. In mode 0, `fsxIn` and `fsrIn` are 0. In mode 1, `uartRx` is 1 and `gpioIn` is 0.
- R7: In mode 0, pin 1 is never driven: `pad1Oe` is 0 and `pad1Out` is 0.
- R8: `modeSel` reads 1 when the frame-sync mode is committed and 0 for the GPIO/UART mode.
- R9: Asserting reset again resamples the strap, so a new release can commit the other mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset; the strap is watched while it is low |
| strapIn | input | 1 | Mode strap level |
| pad0In | input | 1 | Input level from shared pin 0 |
| pad0Oe | output | 1 | Output enable for shared pin 0 |
| pad0Out | output | 1 | Output data for shared pin 0 |
| pad1In | input | 1 | Input level from shared pin 1 |
| pad1Oe | output | 1 | Output enable for shared pin 1 |
| pad1Out | output | 1 | Output data for shared pin 1 |
| gpioOe | input | 1 | GPIO bit 5 output enable |
| gpioOut | input | 1 | GPIO bit 5 output data |
| gpioIn | output | 1 | GPIO bit 5 input level |
| uartRx | output | 1 | UART receive data |
| fsxOe | input | 1 | Transmit frame-sync output enable |
| fsxOut | input | 1 | Transmit frame-sync output data |
| fsxIn | output | 1 | Transmit frame-sync input level |
| fsrOe | input | 1 | Receive frame-sync output enable |
| fsrOut | input | 1 | Receive frame-sync output data |
| fsrIn | output | 1 | Receive frame-sync input level |
| modeSel | output | 1 | Committed mode, 1 = frame-sync mode |

## Verification
The hardest case to reach from the ports is a strap edge that arrives only a few clock edges before reset release, while the synchronizer still holds the old level. The bench moves the strap at a chosen number of edges before it raises reset, from zero to five, for every pair of old and new levels. It then compares the committed mode with the stable-edge count. After each release it drives all 256 combinations of the pad inputs and peripheral outputs and checks the routing.

// File: rtl/pin_mux_pkg.sv
package pin_mux_pkg;

  typedef enum logic {
    MODE_GPIO_UART  = 1'b0,
    MODE_FRAME_SYNC = 1'b1
  } pin_mode_e;

  typedef struct packed {
    logic fsMode;       // committed mode is frame sync
    logic padsEnabled;  // pad drivers allowed
  } mux_strobe_t;

endpackage

// File: rtl/pin_mux_ctrl.sv
module pin_mux_ctrl
  import pin_mux_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        strapIn,
  output mux_strobe_t strobe
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] syncQ;
  pin_mode_e     modeQ;
  logic          enQ;

  // synchronizer runs freely so the strap is seen while reset is held
  generate
    if (SYNC_STAGES == 1) begin : g_single
      always_ff @(posedge clk) syncQ <= strapIn;
    end else begin : g_chain
      always_ff @(posedge clk) syncQ <= {syncQ[LAST-1:0], strapIn};
    end
  endgenerate

  // mode follows the synchronized strap while reset is low, frozen after
  always_ff @(posedge clk) begin
    if (!rstN) modeQ <= pin_mode_e'(syncQ[LAST]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) enQ <= 1'b0;
    else       enQ <= 1'b1;
  end

  assign strobe.fsMode      = (modeQ == MODE_FRAME_SYNC);
  assign strobe.padsEnabled = enQ;

  p_mode_frozen_r3: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> $stable(modeQ));

  p_enable_after_release_r5: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> enQ);

endmodule

// File: rtl/pin_mux_datapath.sv
module pin_mux_datapath
  import pin_mux_pkg::*;
#(
  parameter logic UART_IDLE = 1'b1,
  parameter logic FS_IDLE   = 1'b0,
  parameter logic GPIO_IDLE = 1'b0
) (
  input  mux_strobe_t strobe,
  input  logic        pad0In,
  output logic        pad0Oe,
  output logic        pad0Out,
  input  logic        pad1In,
  output logic        pad1Oe,
  output logic        pad1Out,
  input  logic        gpioOe,
  input  logic        gpioOut,
  output logic        gpioIn,
  output logic        uartRx,
  input  logic        fsxOe,
  input  logic        fsxOut,
  output logic        fsxIn,
  input  logic        fsrOe,
  input  logic        fsrOut,
  output logic        fsrIn
);

  logic en;
  assign en = strobe.padsEnabled;

  always_comb begin
    if (strobe.fsMode) begin
      pad0Oe  = en & fsxOe;
      pad0Out = fsxOut;
      pad1Oe  = en & fsrOe;
      pad1Out = fsrOut;
      fsxIn   = pad0In;
      fsrIn   = pad1In;
      gpioIn  = GPIO_IDLE;
      uartRx  = UART_IDLE;
    end else begin
      pad0Oe  = en & gpioOe;
      pad0Out = gpioOut;
      pad1Oe  = 1'b0;
      pad1Out = 1'b0;
      gpioIn  = pad0In;
      uartRx  = pad1In;
      fsxIn   = FS_IDLE;
      fsrIn   = FS_IDLE;
    end
  end

  always_comb begin
    if (!en) p_pads_input_r5: assert (!pad0Oe && !pad1Oe);
    if (!strobe.fsMode) p_rx_pin_undriven_r7: assert (!pad1Oe && !pad1Out);
    if (!strobe.fsMode) p_idle_fs_r6: assert (fsxIn == FS_IDLE && fsrIn == FS_IDLE);
    else                p_idle_uart_r6: assert (uartRx == UART_IDLE && gpioIn == GPIO_IDLE);
  end

endmodule

// File: rtl/pin_strap_mux.sv
module pin_strap_mux
  import pin_mux_pkg::*;
#(
  parameter int   SYNC_STAGES = 2,
  parameter logic UART_IDLE   = 1'b1,
  parameter logic FS_IDLE     = 1'b0,
  parameter logic GPIO_IDLE   = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic strapIn,
  input  logic pad0In,
  output logic pad0Oe,
  output logic pad0Out,
  input  logic pad1In,
  output logic pad1Oe,
  output logic pad1Out,
  input  logic gpioOe,
  input  logic gpioOut,
  output logic gpioIn,
  output logic uartRx,
  input  logic fsxOe,
  input  logic fsxOut,
  output logic fsxIn,
  input  logic fsrOe,
  input  logic fsrOut,
  output logic fsrIn,
  output logic modeSel
);

  mux_strobe_t strobe;

  pin_mux_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .strapIn(strapIn), .strobe(strobe)
  );

  pin_mux_datapath #(.UART_IDLE(UART_IDLE), .FS_IDLE(FS_IDLE), .GPIO_IDLE(GPIO_IDLE)) u_dp (
    .strobe(strobe),
    .pad0In(pad0In), .pad0Oe(pad0Oe), .pad0Out(pad0Out),
    .pad1In(pad1In), .pad1Oe(pad1Oe), .pad1Out(pad1Out),
    .gpioOe(gpioOe), .gpioOut(gpioOut), .gpioIn(gpioIn),
    .uartRx(uartRx),
    .fsxOe(fsxOe), .fsxOut(fsxOut), .fsxIn(fsxIn),
    .fsrOe(fsrOe), .fsrOut(fsrOut), .fsrIn(fsrIn)
  );

  assign modeSel = strobe.fsMode;

endmodule

// File: tb/pin_strap_mux_bench.sv
module pin_strap_mux_bench;

  localparam int STAGES = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic strapIn = 1'b0;
  logic pad0In = 1'b0, pad1In = 1'b0;
  logic gpioOe = 1'b0, gpioOut = 1'b0, fsxOe = 1'b0, fsxOut = 1'b0, fsrOe = 1'b0, fsrOut = 1'b0;
  logic pad0Oe, pad0Out, pad1Oe, pad1Out, gpioIn, uartRx, fsxIn, fsrIn, modeSel;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  pin_strap_mux #(.SYNC_STAGES(STAGES)) u_pin_strap_mux (
    .clk(clk), .rstN(rstN), .strapIn(strapIn),
    .pad0In(pad0In), .pad0Oe(pad0Oe), .pad0Out(pad0Out),
    .pad1In(pad1In), .pad1Oe(pad1Oe), .pad1Out(pad1Out),
    .gpioOe(gpioOe), .gpioOut(gpioOut), .gpioIn(gpioIn), .uartRx(uartRx),
    .fsxOe(fsxOe), .fsxOut(fsxOut), .fsxIn(fsxIn),
    .fsrOe(fsrOe), .fsrOut(fsrOut), .fsrIn(fsrIn),
    .modeSel(modeSel)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  function automatic logic [7:0] expRoute(input logic fs, input logic [7:0] v);
    // v = {pad0In,pad1In,gpioOe,gpioOut,fsxOe,fsxOut,fsrOe,fsrOut}
    // result = {pad0Oe,pad0Out,pad1Oe,pad1Out,gpioIn,uartRx,fsxIn,fsrIn}
    if (fs) return {v[3], v[2], v[1], v[0], 1'b0, 1'b1, v[7], v[6]};
    return {v[5], v[4], 2'b00, v[7], v[6], 2'b00};
  endfunction

  function automatic logic [7:0] actRoute();
    return {pad0Oe, pad0Out, pad1Oe, pad1Out, gpioIn, uartRx, fsxIn, fsrIn};
  endfunction

  task automatic setIn(input logic [7:0] v);
    {pad0In, pad1In, gpioOe, gpioOut, fsxOe, fsxOut, fsrOe, fsrOut} = v;
  endtask

  // hold strap at a, switch to b, k edges later release reset
  task automatic strapReset(input logic a, input logic b, input int k);
    @(negedge clk);
    rstN = 1'b0;
    strapIn = a;
    setIn(8'hFF);
    repeat (5) @(negedge clk);
    chk("R5 oe in reset", {6'b0, pad0Oe, pad1Oe}, 8'h00);
    strapIn = b;
    repeat (k) @(negedge clk);
    rstN = 1'b1;
    #1;
    chk("R5 oe before first edge", {6'b0, pad0Oe, pad1Oe}, 8'h00);
    @(negedge clk);
  endtask

  logic prevMode = 1'b0;
  bit   havePrev = 1'b0;

  initial begin
    #(20 * 200000);
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int k = 0; k <= 5; k++) begin
      for (int ab = 0; ab < 4; ab++) begin
        logic a, b, expMode;
        a = ab[1];
        b = ab[0];
        strapReset(a, b, k);
        expMode = (k >= STAGES + 1) ? b : a;
        chk("R4 R8 committed mode", {7'b0, modeSel}, {7'b0, expMode});
        if (havePrev && prevMode != expMode)
          chk("R9 resample changes mode", {7'b0, modeSel}, {7'b0, expMode});
        prevMode = expMode;
        havePrev = 1'b1;
        for (int v = 0; v < 256; v++) begin
          setIn(v[7:0]);
          #1;
          if (expMode) chk("R2 R6 frame-sync routing", actRoute(), expRoute(1'b1, v[7:0]));
          else         chk("R1 R6 R7 gpio/uart routing", actRoute(), expRoute(1'b0, v[7:0]));
        end
        // strap wiggles after release must not move the mode
        for (int t = 0; t < 4; t++) begin
          @(negedge clk);
          strapIn = ~strapIn;
        end
        repeat (4) @(negedge clk);
        chk("R3 mode frozen", {7'b0, modeSel}, {7'b0, expMode});
        setIn(8'b10_1111_11);
        #1;
        chk("R3 routing frozen", actRoute(), expRoute(expMode, 8'b10_1111_11));
      end
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule